// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each incoming Ethernet frame, whether the receive path keeps it, using only the frame's 48-bit destination address. The address arrives on a bus together with a one-cycle strobe. A fixed two cycles later the block gives an accept decision and a small classification record. The record says whether the address was broadcast or multicast, whether the multicast hash table matched, whether an exact-match slot matched, and which slot that was.

Configuration comes in as static ports driven by a register file elsewhere in the chip. It holds four exact-match address slots, a 64-bit multicast hash table, a promiscuous bit and a hash-enable bit. Slot 0 normally holds the station's own address and slots 1 to 3 hold multicast groups. An all-zero slot counts as empty. The hash index is taken from the standard Ethernet CRC-32 of the address, computed in parallel in one cycle.

Address byte order on every address port: byte 0, the first byte on the wire, sits in bits [7:0], byte 1 in [15:8], and so on. The low, middle and high 16-bit halves of an address are bits [15:0], [31:16] and [47:32].

Top module: `rx_da_filter`

## Requirements
- R1: A strobe on `da_valid` at clock edge N gives `res_valid` high for exactly one cycle after edge N+2. Strobes on consecutive cycles give results on consecutive cycles. While `res_valid` is low, every other result output is 0.
- R2: After synchronous active-low reset, every output is 0.
- R3: The all-ones address is always accepted. It sets `res_bcast` and no other flag, and `res_slot` is 0.
- R4: A non-broadcast address is multicast, and raises `res_mcast`, exactly when bit 0 of byte 0 (`da[0]`) is 1.
- R5: A non-broadcast address equal to a non-zero slot is accepted. It raises `res_exact_hit`, and `res_slot` gives that slot's number. Slot s is `cfg_slots[48*s +: 48]`. With no exact hit, `res_slot` is 0.
- R6: When several slots hold the matching address, `res_slot` reports the lowest-numbered one.
- R7: A slot whose 48 bits are all zero never matches, not even the all-zero address.
- R8: The hash index is the top 6 bits, [31:26], of a CRC-32 over the address with these settings: polynomial 0x04C11DB7, register initialised to all ones, bytes 0 to 5 in order, each byte LSB first, no final inversion. Index bits [5:4] pick the 16-bit table word `cfg_hash_tbl[16*w +: 16]` and bits [3:0] pick the bit in it. With `cfg_hash_en` = 1, a multicast address whose table bit is 1 raises `res_hash_hit` and is accepted.
- R9: The hash table has no effect on unicast or broadcast addresses, and no effect at all while `cfg_hash_en` = 0.
- R10: With `cfg_promisc` = 1, every address is accepted. The classification flags are still reported as without promiscuous mode.
- R11: A hash table of all ones with hash enabled accepts every multicast address.
- R12: An address that is not broadcast, matches no slot, and gets no hash hit is rejected when promiscuous mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| da_valid | input | 1 | Strobe: `da` holds a destination address |
| da | input | 48 | Destination address, byte 0 in bits [7:0] |
| cfg_promisc | input | 1 | Accept every address |
| cfg_hash_en | input | 1 | Enable multicast hash acceptance |
| cfg_slots | input | 192 | Four exact-match addresses, slot s at [48s+47:48s] |
| cfg_hash_tbl | input | 64 | Hash table, four 16-bit words, word w at [16w+15:16w] |
| res_valid | output | 1 | Result valid, two cycles after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_bcast | output | 1 | Address is broadcast |
| res_mcast | output | 1 | Address is multicast (not broadcast) |
| res_hash_hit | output | 1 | Multicast hash table hit |
| res_exact_hit | output | 1 | Exact-match slot hit |
| res_slot | output | 2 | Lowest matching slot number |

## Verification
The table-driven part sends broadcast, station, multicast-slot, unmatched unicast, all-zero and hash-only addresses, each under several promiscuous and hash-enable settings. These tell apart the exact-match, hash and broadcast paths, and show whether a control bit leaks into the wrong path. Hash expectations come from a CRC written in the bench in reflected, shift-right form, so a wrong polynomial, bit order or index slice in the design gives a different table bit. Directed cases cover the rest: a single table bit moved across all four words, an all-ones table with both multicast and unicast addresses, duplicated slots for the priority order, and back-to-back strobes for the fixed latency.

// File: rtl/daf_pkg.sv
// Shared constants and types for the receive destination address filter.
// Assumes 48-bit addresses with byte 0 in bits [7:0], each byte sent LSB first.
package daf_pkg;
    localparam int          DAF_ADDR_W     = 48;
    localparam int          DAF_NUM_SLOTS  = 4;
    localparam int          DAF_HASH_IDX_W = 6;
    localparam int          DAF_HASH_WORD  = 16;
    localparam int          DAF_CRC_W      = 32;
    localparam logic [31:0] DAF_CRC_POLY   = 32'h04C1_1DB7;
    localparam logic [31:0] DAF_CRC_SEED   = 32'hFFFF_FFFF;

    // Classification flags carried from the compare stage to the outputs.
    typedef struct packed {
        logic bcast;
        logic mcast;
        logic hash_hit;
        logic exact_hit;
    } daf_flags_t;
endpackage

// File: rtl/daf_hash_index.sv
// Parallel CRC-32 over one destination address. It returns the top IDX_W bits
// of the CRC register, which index the multicast hash table.
// Assumes: the address bits are fed in wire order, addr[0] first; the register
// starts at all ones; the CRC is not inverted at the end. Purely combinational.
module daf_hash_index #(
    parameter int ADDR_W = daf_pkg::DAF_ADDR_W,
    parameter int IDX_W  = daf_pkg::DAF_HASH_IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int CRC_W = daf_pkg::DAF_CRC_W;

    logic [CRC_W-1:0] crc;

    // Unrolled MSB-first CRC shift, one step per address bit.
    always_comb begin
        crc = daf_pkg::DAF_CRC_SEED;
        for (int i = 0; i < ADDR_W; i++) begin
            if (crc[CRC_W-1] ^ addr[i])
                crc = {crc[CRC_W-2:0], 1'b0} ^ daf_pkg::DAF_CRC_POLY;
            else
                crc = {crc[CRC_W-2:0], 1'b0};
        end
        idx = crc[CRC_W-1 -: IDX_W];
    end
endmodule

// File: rtl/daf_exact_match.sv
// Compares one address against NUM_SLOTS configured addresses. A slot that is
// all zero is empty and never matches. It reports whether any slot matched and
// the lowest matching slot number.
// Assumes: slot s is slots[ADDR_W*s +: ADDR_W]; clk and rst_n feed only the check.
module daf_exact_match #(
    parameter int ADDR_W    = daf_pkg::DAF_ADDR_W,
    parameter int NUM_SLOTS = daf_pkg::DAF_NUM_SLOTS,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_SLOTS*ADDR_W-1:0] slots,
    output logic                        hit,
    output logic [SLOT_W-1:0]           slot
);
    logic [NUM_SLOTS-1:0] slot_hit;

    // One comparator per slot; an empty slot is masked out.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [ADDR_W-1:0] entry;
        assign entry       = slots[ADDR_W*s +: ADDR_W];
        assign slot_hit[s] = (entry != '0) && (entry == addr);
    end

    // Priority encoder: scanning downward lets the lowest matching slot win.
    always_comb begin
        hit  = |slot_hit;
        slot = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (slot_hit[s])
                slot = SLOT_W'(s);
        end
    end

    AST_LOWEST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (slot_hit[slot] && ((slot_hit & ~({NUM_SLOTS{1'b1}} << slot)) == '0))); // R6
endmodule

// File: rtl/rx_da_filter.sv
// Receive destination address filter. Stage 1 registers the strobed address.
// Stage 2 registers the decision: broadcast check, multicast bit, exact-match
// slots and the CRC-indexed hash table. The result is valid two cycles after
// the strobe.
// Assumes: configuration is quasi-static and is read while the address sits in
// stage 1; reset is synchronous and active low.
module rx_da_filter #(
    parameter int ADDR_W      = daf_pkg::DAF_ADDR_W,
    parameter int NUM_SLOTS   = daf_pkg::DAF_NUM_SLOTS,
    parameter int HASH_IDX_W  = daf_pkg::DAF_HASH_IDX_W,
    parameter int HASH_WORD_W = daf_pkg::DAF_HASH_WORD,
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int HASH_BITS  = 2 ** HASH_IDX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        da_valid,
    input  logic [ADDR_W-1:0]           da,
    input  logic                        cfg_promisc,
    input  logic                        cfg_hash_en,
    input  logic [NUM_SLOTS*ADDR_W-1:0] cfg_slots,
    input  logic [HASH_BITS-1:0]        cfg_hash_tbl,
    output logic                        res_valid,
    output logic                        res_accept,
    output logic                        res_bcast,
    output logic                        res_mcast,
    output logic                        res_hash_hit,
    output logic                        res_exact_hit,
    output logic [SLOT_W-1:0]           res_slot
);
    import daf_pkg::*;

    localparam int BIT_SEL_W  = $clog2(HASH_WORD_W);
    localparam int WORD_SEL_W = HASH_IDX_W - BIT_SEL_W;

    logic                   valid_q;
    logic [ADDR_W-1:0]      da_q;
    logic [HASH_IDX_W-1:0]  hash_idx;
    logic [WORD_SEL_W-1:0]  word_sel;
    logic [BIT_SEL_W-1:0]   bit_sel;
    logic [HASH_WORD_W-1:0] hash_word;
    logic                   ex_hit;
    logic [SLOT_W-1:0]      ex_slot;
    daf_flags_t             flags_d;
    logic                   accept_d;
    daf_flags_t             flags_q;

    // Stage 1: hold the strobed address for the compare stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            da_q    <= '0;
        end else begin
            valid_q <= da_valid;
            if (da_valid)
                da_q <= da;
        end
    end

    daf_hash_index #(.ADDR_W(ADDR_W), .IDX_W(HASH_IDX_W)) u_hash (
        .addr (da_q),
        .idx  (hash_idx)
    );

    daf_exact_match #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_exact (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (da_q),
        .slots (cfg_slots),
        .hit   (ex_hit),
        .slot  (ex_slot)
    );

    // Hash table lookup: upper index bits pick the word, lower bits the bit.
    always_comb begin
        word_sel  = hash_idx[HASH_IDX_W-1 -: WORD_SEL_W];
        bit_sel   = hash_idx[BIT_SEL_W-1:0];
        hash_word = cfg_hash_tbl[word_sel*HASH_WORD_W +: HASH_WORD_W];
    end

    // Classification and the accept decision; broadcast masks the other paths.
    always_comb begin
        flags_d.bcast     = &da_q;
        flags_d.mcast     = da_q[0] & ~flags_d.bcast;
        flags_d.hash_hit  = flags_d.mcast & cfg_hash_en & hash_word[bit_sel];
        flags_d.exact_hit = ex_hit & ~flags_d.bcast;
        accept_d          = cfg_promisc | flags_d.bcast | flags_d.hash_hit
                          | flags_d.exact_hit;
    end

    // Stage 2: register the result; all fields stay zero without a valid address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            flags_q    <= '0;
            res_slot   <= '0;
        end else if (valid_q) begin
            res_valid  <= 1'b1;
            res_accept <= accept_d;
            flags_q    <= flags_d;
            res_slot   <= flags_d.exact_hit ? ex_slot : '0;
        end else begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            flags_q    <= '0;
            res_slot   <= '0;
        end
    end

    assign res_bcast     = flags_q.bcast;
    assign res_mcast     = flags_q.mcast;
    assign res_hash_hit  = flags_q.hash_hit;
    assign res_exact_hit = flags_q.exact_hit;

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |-> ##2 res_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |-> ##2 !res_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_accept | res_bcast | res_mcast | res_hash_hit | res_exact_hit)); // R1
    AST_BCAST_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        res_bcast |-> (res_accept && !res_mcast && !res_hash_hit && !res_exact_hit && res_slot == '0)); // R3
    AST_HASH_NEEDS_MCAST: assert property (@(posedge clk) disable iff (!rst_n)
        res_hash_hit |-> res_mcast); // R9
    AST_SLOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !res_exact_hit |-> (res_slot == '0)); // R5
    AST_REJECT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_accept) |-> !(res_exact_hit | res_hash_hit | res_bcast)); // R12
endmodule

// File: tb/rx_da_filter_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop, then directed cases.
module rx_da_filter_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         da_valid = 1'b0;
    logic [47:0]  da = '0;
    logic         cfg_promisc = 1'b0;
    logic         cfg_hash_en = 1'b0;
    logic [191:0] cfg_slots = '0;
    logic [63:0]  cfg_hash_tbl = '0;
    logic         res_valid, res_accept, res_bcast, res_mcast, res_hash_hit, res_exact_hit;
    logic [1:0]   res_slot;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    rx_da_filter u_rx_da_filter (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
        .cfg_promisc(cfg_promisc), .cfg_hash_en(cfg_hash_en),
        .cfg_slots(cfg_slots), .cfg_hash_tbl(cfg_hash_tbl),
        .res_valid(res_valid), .res_accept(res_accept), .res_bcast(res_bcast),
        .res_mcast(res_mcast), .res_hash_hit(res_hash_hit),
        .res_exact_hit(res_exact_hit), .res_slot(res_slot)
    );

    localparam logic [47:0] A_BC = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] A_S0 = 48'h6655_4433_2210;
    localparam logic [47:0] A_S1 = 48'hFB00_005E_0001;
    localparam logic [47:0] A_S3 = 48'h0E00_000C_CC01;
    localparam logic [47:0] A_H1 = 48'h3322_1100_5E01;
    localparam logic [47:0] A_U1 = 48'h9988_7766_5544;

    typedef struct packed {
        logic [47:0] da;
        logic        pr;
        logic        he;
        logic        acc;
        logic        bc;
        logic        mc;
        logic        ex;
        logic [1:0]  slot;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{A_BC, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'd3},   // R3 broadcast
        '{A_S0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 4'd5},   // R5 station slot
        '{A_S1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 4'd5},   // R5 multicast slot
        '{A_S3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 4'd4},   // R4 mcast flag, slot 3
        '{A_U1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd12},  // R12 reject
        '{A_U1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'd10},  // R10 promiscuous
        '{A_H1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd9},   // R9 hash disabled
        '{A_H1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 4'd8},   // R8 hash hit
        '{48'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd7},  // R7 empty slot
        '{A_BC, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'd3},   // R3 broadcast, all modes on
        '{A_H1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 4'd10}   // R10 flags kept
    };

    // Reference hash index: reflected CRC-32, register reversed at the end.
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            if (r[0] ^ a[i]) r = (r >> 1) ^ 32'hEDB8_8320;
            else             r = r >> 1;
        end
        return {r[0], r[1], r[2], r[3], r[4], r[5]};
    endfunction

    function automatic logic ref_hash(input logic [47:0] a, input logic en,
                                      input logic [63:0] tbl);
        logic [5:0] k = ref_idx(a);
        return en & a[0] & ~(&a) & tbl[{k[5:4], 4'b0000} + {2'b00, k[3:0]}];
    endfunction

    function automatic logic [7:0] pack_exp(input logic v, input logic acc, input logic bc,
                                            input logic mc, input logic hh, input logic ex,
                                            input logic [1:0] sl);
        return {v, acc, bc, mc, hh, ex, sl};
    endfunction

    function automatic logic [7:0] outs();
        return {res_valid, res_accept, res_bcast, res_mcast, res_hash_hit, res_exact_hit, res_slot};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b (valid,acc,bc,mc,hash,exact,slot)", tag, got, exp);
        end
    endtask

    // Strobe one address, then sample at the falling edge after the second rising edge.
    task automatic send(input logic [47:0] a, output logic [7:0] got);
        @(negedge clk);
        da = a;
        da_valid = 1'b1;
        @(negedge clk);
        da_valid = 1'b0;
        @(negedge clk);
        got = outs();
    endtask

    initial begin
        logic [7:0] got;
        logic       hh;

        cfg_slots = {A_S3, 48'h0, A_S1, A_S0};
        cfg_hash_tbl = '0;
        cfg_hash_tbl[ref_idx(A_H1)] = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 outputs during reset", outs(), 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 outputs after reset", outs(), 8'h00);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            cfg_promisc = VECS[v].pr;
            cfg_hash_en = VECS[v].he;
            hh = ref_hash(VECS[v].da, VECS[v].he, cfg_hash_tbl);
            send(VECS[v].da, got);
            check($sformatf("R%0d vector %0d", VECS[v].req, v), got,
                  pack_exp(1'b1, VECS[v].acc, VECS[v].bc, VECS[v].mc, hh, VECS[v].ex, VECS[v].slot));
        end

        // R1: fixed latency and back-to-back strobes.
        cfg_promisc = 1'b0;
        cfg_hash_en = 1'b0;
        @(negedge clk);
        da = A_S0; da_valid = 1'b1;
        @(negedge clk);
        check("R1 no result one cycle after strobe", outs(), 8'h00);
        da = A_U1;
        @(negedge clk);
        da_valid = 1'b0;
        check("R1 first of back-to-back", outs(), pack_exp(1, 1, 0, 0, 0, 1, 2'd0));
        @(negedge clk);
        check("R1 second of back-to-back", outs(), pack_exp(1, 0, 0, 0, 0, 0, 2'd0));
        @(negedge clk);
        check("R1 valid drops after one cycle", outs(), 8'h00);

        // R8: one table bit at a time, walked across several addresses and words.
        cfg_hash_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            logic [47:0] a = {8'h3C, 8'(k * 37), 24'hA1B2C3, 8'(2 * k + 3)};
            cfg_hash_tbl = '0;
            cfg_hash_tbl[ref_idx(a)] = 1'b1;
            send(a, got);
            check($sformatf("R8 single table bit %0d", ref_idx(a)), got, pack_exp(1, 1, 0, 1, 1, 0, 2'd0));
            cfg_hash_tbl = ~cfg_hash_tbl;
            hh = ref_hash(a, 1'b1, cfg_hash_tbl);
            send(a, got);
            check("R8 only that bit cleared", got, pack_exp(1, hh, 0, 1, hh, 0, 2'd0));
        end

        // R11: an all-ones table accepts multicast; R9: unicast still ignored.
        cfg_hash_tbl = '1;
        for (int k = 0; k < 4; k++) begin
            send({40'hC3_3C0F_5AA5 + 40'(k), 8'(4 * k + 1)}, got);
            check("R11 all-ones table multicast", got, pack_exp(1, 1, 0, 1, 1, 0, 2'd0));
        end
        send(A_U1, got);
        check("R9 unicast ignores full table", got, pack_exp(1, 0, 0, 0, 0, 0, 2'd0));
        cfg_hash_en = 1'b0;
        send(A_H1, got);
        check("R9 full table with hash disabled", got, pack_exp(1, 0, 0, 1, 0, 0, 2'd0));

        // R6: duplicate entries report the lowest slot.
        cfg_hash_tbl = '0;
        cfg_slots = {A_S3, A_S3, A_S1, A_S0};
        send(A_S3, got);
        check("R6 lowest duplicate slot", got, pack_exp(1, 1, 0, 1, 0, 1, 2'd2));
        cfg_slots = {A_S1, A_S1, A_S1, A_S1};
        send(A_S1, got);
        check("R6 all slots equal", got, pack_exp(1, 1, 0, 1, 0, 1, 2'd0));

        // R7: the all-zero address never matches empty slots.
        cfg_slots = '0;
        send(48'h0, got);
        check("R7 zero address, all slots empty", got, pack_exp(1, 0, 0, 0, 0, 0, 2'd0));

        // R2: reset in the middle clears a pending result.
        @(negedge clk);
        da = A_BC; da_valid = 1'b1;
        @(negedge clk);
        da_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R2 reset discards pending result", outs(), 8'h00);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule